// File: doc/BRIEF.md
# Register Initialisation Command-Table Sequencer

This block executes a list of register set-up commands stored in a word-addressed table memory. Software or a boot agent writes the table elsewhere. It then pulses a start input with the table's first word address, its length in 32-bit words and a poll retry limit. The sequencer reads the table one word at a time over a simple synchronous read port, with data returned on the cycle after the read strobe. It decodes each variable-length entry from the opcode in the top nibble of its header word and performs the register bus traffic that the entry asks for.

Five entry kinds are understood:

- a plain write to a register offset;
- a write into a selectable index space;
- a read-modify-write that merges new bits under a mask;
- a poll that keeps reading a register until its masked value equals an expected pattern;
- a terminator.

The run ends when the terminator is reached, when an opcode is not recognised, when the table length is used up before a terminator, or when a poll exhausts its retry budget. Each of these endings has its own status code. Busy drops in the same cycle as a one-cycle done pulse.

Top module: `cmdtab_seq`

## Requirements
- R1: A start_i pulse while idle raises busy_o on the next cycle, and the first table read addresses tbl_base_i. Table data is taken in the cycle after tbl_rd_o. A start_i pulse while busy_o is high has no effect on the run in progress.
- R2: A header whose bits [31:28] equal 0x0 is a two-word entry (header, value). It produces one bus write of the value to address header[27:0], with rb_indir_o low and rb_space_o zero.
- R3: A header whose bits [31:28] equal 0x8 is a two-word entry (header, value). It produces one bus write with rb_addr_o equal to header[19:0] zero-extended, rb_space_o equal to header[27:20], and rb_indir_o high.
- R4: A header whose bits [31:28] equal 0x3 is a three-word entry (header, data, mask). It performs one bus read of header[27:0], then one write to the same address of (old & ~mask) | (data & mask).
- R5: A header whose bits [31:28] equal 0x2 is a three-word entry (header, mask, expected). It reads header[27:0] repeatedly until (read & mask) == (expected & mask), and then moves on to the next entry without any write.
- R6: poll_limit_i is sampled at start. A poll performs at most poll_limit_i+1 reads. If all of them mismatch, the run stops with status 1. A match on the last allowed read counts as success.
- R7: A header whose bits [31:28] equal 0xF is a one-word terminator. It ends the run with status 0.
- R8: Any other opcode ends the run with status 2, with no bus access for that entry.
- R9: If the next word needed lies at or beyond tbl_base_i+tbl_len_i, the run ends with status 3. That word is not read, and a truncated entry causes no bus access.
- R10: rb_rd_o and rb_wr_o are never high together. A bus request holds its address and write data unchanged until rb_ready_i, and each accepted write happens exactly once.
- R11: Every run ends with busy_o falling and done_o high for exactly one cycle, both in the same cycle. status_o keeps the final code until the next accepted start.
- R12: After reset, busy_o, done_o, tbl_rd_o, rb_rd_o and rb_wr_o are low and status_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (ignored while busy) |
| tbl_base_i | input | AW | Word address of the first table entry |
| tbl_len_i | input | AW | Table length in words |
| poll_limit_i | input | TW | Mismatching poll reads allowed before the final one |
| tbl_rd_o | output | 1 | Table read strobe |
| tbl_addr_o | output | AW | Table word address |
| tbl_data_i | input | 32 | Table word, valid the cycle after the strobe |
| rb_rd_o | output | 1 | Register bus read request |
| rb_wr_o | output | 1 | Register bus write request |
| rb_addr_o | output | 28 | Register offset |
| rb_space_o | output | 8 | Index-space selector for indirect writes |
| rb_indir_o | output | 1 | High for an indirect (index-space) write |
| rb_wdata_o | output | 32 | Write data |
| rb_rdata_i | input | 32 | Read data, valid with rb_ready_i |
| rb_ready_i | input | 1 | Completes the current bus request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| status_o | output | 2 | 0 ok, 1 poll timeout, 2 bad opcode, 3 table overrun |

## Verification
A poll's retry limit and its match test can both resolve on the same read: the read that would exhaust the budget may also be the one that matches. The bench sets this up with a polled register that returns its own read count, masked against an expected value reached on exactly the last allowed read. With one less retry allowed, the same table must instead time out after three reads. A second coincidence is the terminator sitting in the final word of the table. In that case status must be 0 rather than an overrun, and this is judged from status_o together with the count of bus writes seen by the register model.

// File: rtl/cmdtab_pkg.sv
package cmdtab_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFFS_W = 28;
  localparam int unsigned SPC_W  = 8;

  // opcode values held in the top nibble of each header word
  localparam logic [3:0] OPC_DWR  = 4'h0;
  localparam logic [3:0] OPC_POLL = 4'h2;
  localparam logic [3:0] OPC_RMW  = 4'h3;
  localparam logic [3:0] OPC_IWR  = 4'h8;
  localparam logic [3:0] OPC_END  = 4'hF;

  typedef enum logic [2:0] {
    K_WRITE,
    K_POLL,
    K_RMW,
    K_END,
    K_BAD
  } kind_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_BADOP   = 2'd2,
    ST_OVERRUN = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HREQ,
    S_HCAP,
    S_OREQ,
    S_OCAP,
    S_READ,
    S_WRITE
  } state_e;

endpackage

// File: rtl/cmdtab_decode.sv
module cmdtab_decode
  import cmdtab_pkg::*;
(
  input  logic [WORD_W-1:0] hdr_i,
  output kind_e             kind_o,
  output logic [1:0]        nops_o,
  output logic              indir_o,
  output logic [OFFS_W-1:0] addr_o,
  output logic [SPC_W-1:0]  space_o
);

  logic [3:0] opc;

  assign opc = hdr_i[WORD_W-1 -: 4];

  always_comb begin
    kind_o  = K_BAD;
    nops_o  = 2'd0;
    indir_o = 1'b0;
    addr_o  = hdr_i[OFFS_W-1:0];
    space_o = '0;
    case (opc)
      OPC_DWR: begin
        kind_o = K_WRITE;
        nops_o = 2'd1;
      end
      OPC_IWR: begin
        kind_o  = K_WRITE;
        nops_o  = 2'd1;
        indir_o = 1'b1;
        addr_o  = {{(OFFS_W-20){1'b0}}, hdr_i[19:0]};
        space_o = hdr_i[27:20];
      end
      OPC_POLL: begin
        kind_o = K_POLL;
        nops_o = 2'd2;
      end
      OPC_RMW: begin
        kind_o = K_RMW;
        nops_o = 2'd2;
      end
      OPC_END: kind_o = K_END;
      default: kind_o = K_BAD;
    endcase
  end

endmodule

// File: rtl/cmdtab_merge.sv
module cmdtab_merge #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] expect_i,
  output logic [W-1:0] merged_o,
  output logic         match_o
);

  logic [W-1:0] diff;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign merged_o[b] = mask_i[b] ? data_i[b] : old_i[b];
    assign diff[b]     = mask_i[b] & (old_i[b] ^ expect_i[b]);
  end

  assign match_o = ~|diff;

endmodule

// File: rtl/cmdtab_polltmr.sv
module cmdtab_polltmr #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          miss_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en   = clr_i | miss_i;
  assign expire_o = miss_i && (cnt_q == limit_i);

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cmdtab_seq.sv
module cmdtab_seq
  import cmdtab_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] tbl_base_i,
  input  logic [AW-1:0] tbl_len_i,
  input  logic [TW-1:0] poll_limit_i,
  output logic          tbl_rd_o,
  output logic [AW-1:0] tbl_addr_o,
  input  logic [31:0]   tbl_data_i,
  output logic          rb_rd_o,
  output logic          rb_wr_o,
  output logic [27:0]   rb_addr_o,
  output logic [7:0]    rb_space_o,
  output logic          rb_indir_o,
  output logic [31:0]   rb_wdata_o,
  input  logic [31:0]   rb_rdata_i,
  input  logic          rb_ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    status_o
);

  localparam int unsigned PW = AW + 1;

  state_e            state_q, state_d;
  logic [PW-1:0]     ptr_q, ptr_d, end_q, end_d;
  logic [WORD_W-1:0] hdr_q, op0_q, op1_q, wdata_q, wdata_d;
  logic [TW-1:0]     limit_q;
  logic              opn_q, opn_d;
  logic              busy_q, busy_d, done_q, done_d;
  status_e           status_q, status_d;

  logic ld_run, ld_ptr, ld_hdr, ld_op0, ld_op1, ld_wdata, ld_opn, ld_stat;
  logic fin;
  status_e fin_code;
  logic tmr_clr, tmr_miss, tmr_expire;
  logic at_end;

  logic [WORD_W-1:0] dec_in;
  kind_e             kind;
  logic [1:0]        nops;
  logic              d_indir;
  logic [OFFS_W-1:0] d_addr;
  logic [SPC_W-1:0]  d_space;
  logic [WORD_W-1:0] merged, mask_sel;
  logic              match;

  assign dec_in = (state_q == S_HCAP) ? tbl_data_i : hdr_q;

  cmdtab_decode u_dec (
    .hdr_i   (dec_in),
    .kind_o  (kind),
    .nops_o  (nops),
    .indir_o (d_indir),
    .addr_o  (d_addr),
    .space_o (d_space)
  );

  assign mask_sel = (kind == K_POLL) ? op0_q : op1_q;

  cmdtab_merge #(.W(WORD_W)) u_mrg (
    .old_i    (rb_rdata_i),
    .data_i   (op0_q),
    .mask_i   (mask_sel),
    .expect_i (op1_q),
    .merged_o (merged),
    .match_o  (match)
  );

  cmdtab_polltmr #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tmr_clr),
    .miss_i   (tmr_miss),
    .limit_i  (limit_q),
    .expire_o (tmr_expire)
  );

  assign at_end = (ptr_q >= end_q);

  // next-state process
  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q + 1'b1;
    end_d    = {1'b0, tbl_base_i} + {1'b0, tbl_len_i};
    wdata_d  = tbl_data_i;
    opn_d    = 1'b0;
    busy_d   = busy_q;
    done_d   = 1'b0;
    status_d = status_q;
    ld_run   = 1'b0;
    ld_ptr   = 1'b0;
    ld_hdr   = 1'b0;
    ld_op0   = 1'b0;
    ld_op1   = 1'b0;
    ld_wdata = 1'b0;
    ld_opn   = 1'b0;
    ld_stat  = 1'b0;
    fin      = 1'b0;
    fin_code = ST_OK;
    tmr_clr  = 1'b0;
    tmr_miss = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          ld_run   = 1'b1;
          ld_ptr   = 1'b1;
          ptr_d    = {1'b0, tbl_base_i};
          busy_d   = 1'b1;
          status_d = ST_OK;
          ld_stat  = 1'b1;
          state_d  = S_HREQ;
        end
      end
      S_HREQ: begin
        if (at_end) begin
          fin      = 1'b1;
          fin_code = ST_OVERRUN;
        end else begin
          ld_ptr  = 1'b1;
          state_d = S_HCAP;
        end
      end
      S_HCAP: begin
        ld_hdr = 1'b1;
        case (kind)
          K_END: begin
            fin      = 1'b1;
            fin_code = ST_OK;
          end
          K_BAD: begin
            fin      = 1'b1;
            fin_code = ST_BADOP;
          end
          default: begin
            ld_opn  = 1'b1;
            opn_d   = 1'b0;
            state_d = S_OREQ;
          end
        endcase
      end
      S_OREQ: begin
        if (at_end) begin
          fin      = 1'b1;
          fin_code = ST_OVERRUN;
        end else begin
          ld_ptr  = 1'b1;
          state_d = S_OCAP;
        end
      end
      S_OCAP: begin
        if (!opn_q) begin
          ld_op0 = 1'b1;
          if (nops == 2'd1) begin
            ld_wdata = 1'b1;
            state_d  = S_WRITE;
          end else begin
            ld_opn  = 1'b1;
            opn_d   = 1'b1;
            state_d = S_OREQ;
          end
        end else begin
          ld_op1  = 1'b1;
          tmr_clr = 1'b1;
          state_d = S_READ;
        end
      end
      S_READ: begin
        if (rb_ready_i) begin
          if (kind == K_RMW) begin
            wdata_d  = merged;
            ld_wdata = 1'b1;
            state_d  = S_WRITE;
          end else if (match) begin
            state_d = S_HREQ;
          end else begin
            tmr_miss = 1'b1;
            if (tmr_expire) begin
              fin      = 1'b1;
              fin_code = ST_TIMEOUT;
            end
          end
        end
      end
      S_WRITE: begin
        if (rb_ready_i) state_d = S_HREQ;
      end
      default: state_d = S_IDLE;
    endcase

    if (fin) begin
      state_d  = S_IDLE;
      busy_d   = 1'b0;
      done_d   = 1'b1;
      status_d = fin_code;
      ld_stat  = 1'b1;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
      ptr_q    <= '0;
      end_q    <= '0;
      limit_q  <= '0;
      hdr_q    <= '0;
      op0_q    <= '0;
      op1_q    <= '0;
      wdata_q  <= '0;
      opn_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      if (ld_stat)  status_q <= status_d;
      if (ld_ptr)   ptr_q    <= ptr_d;
      if (ld_run)   end_q    <= end_d;
      if (ld_run)   limit_q  <= poll_limit_i;
      if (ld_hdr)   hdr_q    <= tbl_data_i;
      if (ld_op0)   op0_q    <= tbl_data_i;
      if (ld_op1)   op1_q    <= tbl_data_i;
      if (ld_wdata) wdata_q  <= wdata_d;
      if (ld_opn)   opn_q    <= opn_d;
    end
  end

  assign tbl_rd_o   = ((state_q == S_HREQ) || (state_q == S_OREQ)) && !at_end;
  assign tbl_addr_o = ptr_q[AW-1:0];
  assign rb_rd_o    = (state_q == S_READ);
  assign rb_wr_o    = (state_q == S_WRITE);
  assign rb_addr_o  = d_addr;
  assign rb_space_o = d_space;
  assign rb_indir_o = d_indir;
  assign rb_wdata_o = wdata_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign status_o   = status_q;

endmodule

// File: rtl/cmdtab_seq_chk.sv
module cmdtab_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        tbl_rd_o,
  input logic        rb_rd_o,
  input logic        rb_wr_o,
  input logic        rb_ready_i,
  input logic [27:0] rb_addr_o,
  input logic [31:0] rb_wdata_o,
  input logic        busy_o,
  input logic        done_o
);

  // R10
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rb_rd_o && rb_wr_o));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_wr_o && !rb_ready_i) |=> (rb_wr_o && $stable(rb_wdata_o) && $stable(rb_addr_o)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_rd_o && !rb_ready_i) |=> (rb_rd_o && $stable(rb_addr_o)));

  // R11
  fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(tbl_rd_o || rb_rd_o || rb_wr_o));

endmodule

bind cmdtab_seq cmdtab_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .tbl_rd_o   (tbl_rd_o),
  .rb_rd_o    (rb_rd_o),
  .rb_wr_o    (rb_wr_o),
  .rb_ready_i (rb_ready_i),
  .rb_addr_o  (rb_addr_o),
  .rb_wdata_o (rb_wdata_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sim_cmdtab_seq.sv
`timescale 1ns/1ps
module sim_cmdtab_seq;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] base, len;
  logic [15:0] limit;
  logic        tbl_rd;
  logic [15:0] tbl_addr;
  logic [31:0] tbl_q;
  logic        rb_rd, rb_wr, rb_ready, rb_indir;
  logic [27:0] rb_addr;
  logic [7:0]  rb_space;
  logic [31:0] rb_wdata, rb_rdata;
  logic        busy, done;
  logic [1:0]  status;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  cmdtab_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tbl_base_i(base), .tbl_len_i(len),
    .poll_limit_i(limit), .tbl_rd_o(tbl_rd), .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_q),
    .rb_rd_o(rb_rd), .rb_wr_o(rb_wr), .rb_addr_o(rb_addr), .rb_space_o(rb_space),
    .rb_indir_o(rb_indir), .rb_wdata_o(rb_wdata), .rb_rdata_i(rb_rdata),
    .rb_ready_i(rb_ready), .busy_o(busy), .done_o(done), .status_o(status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // table memory model
  logic [31:0] mem [0:63];
  logic        clr;
  logic        seen;
  logic [15:0] first_ta, max_ta;

  always @(posedge clk) begin
    if (clr) begin
      seen     <= 1'b0;
      first_ta <= 16'hFFFF;
      max_ta   <= 16'h0;
    end else if (tbl_rd) begin
      tbl_q <= mem[tbl_addr[5:0]];
      if (!seen) first_ta <= tbl_addr;
      seen <= 1'b1;
      if (tbl_addr > max_ta) max_ta <= tbl_addr;
    end
  end

  // register bus model
  logic [31:0] regs [0:15];
  int          bus_wait;
  int          wcnt;
  int          wr_n, rd_n, overlap;
  logic [31:0] poll_rd;
  logic        pre_en;
  logic [3:0]  pre_idx;
  logic [31:0] pre_val;
  logic [27:0] wl_addr  [0:7];
  logic [7:0]  wl_space [0:7];
  logic        wl_ind   [0:7];
  logic [31:0] wl_data  [0:7];

  assign rb_ready = (rb_rd || rb_wr) && (wcnt == bus_wait);
  assign rb_rdata = (rb_addr == 28'd7) ? poll_rd : regs[rb_addr[3:0]];

  always @(posedge clk) begin
    if (clr) begin
      wcnt    <= 0;
      wr_n    <= 0;
      rd_n    <= 0;
      poll_rd <= 32'h0;
      overlap <= 0;
    end else begin
      if (pre_en) regs[pre_idx] <= pre_val;
      if ((rb_rd || rb_wr) && !rb_ready) wcnt <= wcnt + 1;
      else wcnt <= 0;
      if (rb_rd && rb_wr) overlap <= overlap + 1;
      if (rb_ready && rb_wr) begin
        if (wr_n < 8) begin
          wl_addr[wr_n]  <= rb_addr;
          wl_space[wr_n] <= rb_space;
          wl_ind[wr_n]   <= rb_indir;
          wl_data[wr_n]  <= rb_wdata;
        end
        if (!rb_indir) regs[rb_addr[3:0]] <= rb_wdata;
        wr_n <= wr_n + 1;
      end
      if (rb_ready && rb_rd) begin
        rd_n <= rd_n + 1;
        if (rb_addr == 28'd7) poll_rd <= poll_rd + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_models(input int waits);
    @(negedge clk);
    clr      = 1'b1;
    bus_wait = waits;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic preset(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    pre_en  = 1'b1;
    pre_idx = idx;
    pre_val = val;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic kick(input logic [15:0] b, input logic [15:0] l, input logic [15:0] lim);
    @(negedge clk);
    start = 1'b1;
    base  = b;
    len   = l;
    limit = lim;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R1 busy after start", {31'b0, busy}, 32'd1);
  endtask

  task automatic wait_done(output logic [1:0] st);
    int n = 0;
    while (done !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1 && busy === 1'b0, "R11 done with busy low", {30'b0, busy, done}, 32'd1);
    st = status;
    @(negedge clk);
    chk(done === 1'b0, "R11 done one cycle", {31'b0, done}, 32'd0);
    chk(status === st, "R11 status held", {30'b0, status}, {30'b0, st});
  endtask

  task automatic t_reset;
    chk(busy === 1'b0 && done === 1'b0, "R12 busy/done", {30'b0, busy, done}, 32'd0);
    chk(status === 2'd0, "R12 status", {30'b0, status}, 32'd0);
    chk(!tbl_rd && !rb_rd && !rb_wr, "R12 no requests", {29'b0, tbl_rd, rb_rd, rb_wr}, 32'd0);
  endtask

  task automatic t_writes;
    logic [1:0] st;
    clear_models(0);
    mem[4] = 32'h0000_0001;
    mem[5] = 32'hA5A5_0F0F;
    mem[6] = 32'h83C1_2345;
    mem[7] = 32'h1357_9BDF;
    mem[8] = 32'hF000_0000;
    kick(16'd4, 16'd5, 16'd0);
    wait_done(st);
    chk(st == 2'd0, "R7 end status", {30'b0, st}, 32'd0);
    chk(first_ta == 16'd4, "R1 first table address", {16'b0, first_ta}, 32'd4);
    chk(max_ta == 16'd8, "R7 end in last word", {16'b0, max_ta}, 32'd8);
    chk(wr_n == 2, "R2 write count", wr_n, 32'd2);
    chk(wl_addr[0] == 28'h1 && wl_ind[0] == 1'b0 && wl_space[0] == 8'h0,
        "R2 direct addr", {wl_ind[0], wl_space[0], 23'b0}, 32'h0);
    chk(wl_data[0] == 32'hA5A5_0F0F, "R2 direct data", wl_data[0], 32'hA5A5_0F0F);
    chk(wl_addr[1] == 28'h0012345, "R3 indirect addr", {4'b0, wl_addr[1]}, 32'h0012345);
    chk(wl_space[1] == 8'h3C && wl_ind[1] == 1'b1, "R3 indirect space",
        {23'b0, wl_ind[1], wl_space[1]}, 32'h13C);
    chk(wl_data[1] == 32'h1357_9BDF, "R3 indirect data", wl_data[1], 32'h1357_9BDF);
  endtask

  task automatic t_rmw;
    logic [1:0] st;
    clear_models(2);
    preset(4'd2, 32'h1234_5678);
    mem[10] = 32'h3000_0002;
    mem[11] = 32'hABCD_1111;
    mem[12] = 32'hFFFF_0000;
    mem[13] = 32'hF000_0000;
    kick(16'd10, 16'd4, 16'd0);
    wait_done(st);
    chk(rd_n == 1 && wr_n == 1, "R4 one read one write", rd_n * 16 + wr_n, 32'h11);
    chk(wl_addr[0] == 28'h2, "R4 same address", {4'b0, wl_addr[0]}, 32'h2);
    chk(regs[2] == 32'hABCD_5678, "R4 merged value", regs[2], 32'hABCD_5678);
    chk(overlap == 0, "R10 no rd/wr overlap", overlap, 32'd0);
  endtask

  task automatic t_poll(input logic [15:0] lim, input logic [1:0] exp_st, input int exp_rd);
    logic [1:0] st;
    clear_models(1);
    mem[20] = 32'h2000_0007;
    mem[21] = 32'h0000_00FF;
    mem[22] = 32'hAB00_0003;
    mem[23] = 32'h0000_0003;
    mem[24] = 32'h0000_0001;
    mem[25] = 32'hF000_0000;
    kick(16'd20, 16'd6, lim);
    wait_done(st);
    if (exp_st == 2'd0) begin
      chk(st == exp_st, "R5 poll match status", {30'b0, st}, {30'b0, exp_st});
      chk(rd_n == exp_rd, "R6 match on last allowed read", rd_n, exp_rd);
      chk(wr_n == 1, "R5 no write from poll", wr_n, 32'd1);
    end else begin
      chk(st == exp_st, "R6 timeout status", {30'b0, st}, {30'b0, exp_st});
      chk(rd_n == exp_rd, "R6 read budget", rd_n, exp_rd);
      chk(wr_n == 0, "R6 nothing after timeout", wr_n, 32'd0);
    end
  endtask

  task automatic t_badop;
    logic [1:0] st;
    clear_models(0);
    mem[40] = 32'h5000_0001;
    mem[41] = 32'hF000_0000;
    kick(16'd40, 16'd2, 16'd0);
    wait_done(st);
    chk(st == 2'd2, "R8 bad opcode status", {30'b0, st}, 32'd2);
    chk(rd_n == 0 && wr_n == 0, "R8 no bus access", rd_n + wr_n, 32'd0);
    chk(max_ta == 16'd40, "R8 stop after header", {16'b0, max_ta}, 32'd40);
  endtask

  task automatic t_overrun;
    logic [1:0] st;
    clear_models(0);
    mem[44] = 32'h0000_0003;
    mem[45] = 32'h0000_BEEF;
    kick(16'd44, 16'd1, 16'd0);
    wait_done(st);
    chk(st == 2'd3, "R9 truncated entry status", {30'b0, st}, 32'd3);
    chk(wr_n == 0, "R9 truncated no write", wr_n, 32'd0);
    chk(max_ta == 16'd44, "R9 no read past end", {16'b0, max_ta}, 32'd44);
    clear_models(0);
    kick(16'd44, 16'd2, 16'd0);
    wait_done(st);
    chk(st == 2'd3, "R9 missing end status", {30'b0, st}, 32'd3);
    chk(wr_n == 1 && regs[3] == 32'h0000_BEEF, "R9 complete entry ran", regs[3], 32'h0000_BEEF);
    chk(max_ta == 16'd45, "R9 last read inside table", {16'b0, max_ta}, 32'd45);
  endtask

  task automatic t_busy_start;
    logic [1:0] st;
    clear_models(0);
    kick(16'd4, 16'd5, 16'd0);
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    base  = 16'd40;
    len   = 16'd2;
    @(negedge clk);
    start = 1'b0;
    wait_done(st);
    chk(st == 2'd0, "R1 start while busy ignored", {30'b0, st}, 32'd0);
    chk(wr_n == 2, "R1 original run completed", wr_n, 32'd2);
  endtask

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    base     = '0;
    len      = '0;
    limit    = '0;
    clr      = 1'b1;
    pre_en   = 1'b0;
    pre_idx  = '0;
    pre_val  = '0;
    bus_wait = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'hF000_0000;
    for (int i = 0; i < 16; i++) regs[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_writes();
    t_rmw();
    t_poll(16'd3, 2'd0, 4);
    t_poll(16'd2, 2'd1, 3);
    t_badop();
    t_overrun();
    t_busy_start();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule